// File: doc/BRIEF.md
# PHY Resource Power Sequencer

This controller brings the supporting resources of a SuperSpeed USB PHY up and down in a fixed order. There are eight resources in two groups, and each has an enable output and an acknowledge input. The link group holds the link clock, the auxiliary bus clock, the link reset release and the auxiliary reset release. The PHY group holds the external reference clock, the PHY clock, the PHY reset release and the VBUS supply enable.

An init or exit request walks the link group up or down. A power-on or power-off request does the same for the PHY group. Each step drives one enable and then waits until the matching acknowledge reaches the same level. A shared timer limits how long the wait may last. When a bring-up step fails, its own enable is dropped and the steps already completed in that sequence are undone newest first. The external reference clock and the VBUS supply may be declared absent by configuration inputs, and their steps are then passed over.

The block reports activity on `busy`. It marks the end of each sequence with a one-cycle `done` pulse. The `error` flag holds the outcome of the last accepted request.

Top module: `phy_rsrc_seq`

## Requirements
- R1: Init enables, in this order, res_en[0] (link clock), res_en[1] (auxiliary clock), res_en[2] (link reset release), res_en[3] (auxiliary reset release). The next enable is not driven until res_ack of the current one is high.
- R2: Exit drives the link-group enables low in the order bit 3, bit 2, bit 1, bit 0. Each step waits for its acknowledge to go low.
- R3: Power-on enables, in this order, res_en[4] (external reference clock), res_en[5] (PHY clock), res_en[6] (PHY reset release), res_en[7] (VBUS). Power-off lowers them in the order 7, 6, 5, 4.
- R4: When ext_clk_present is low, res_en[4] never rises and its step is passed over. When vbus_present is low, the same holds for res_en[7].
- R5: After a step drives its enable, the acknowledge must match within cfg_timeout cycles. In a bring-up step a miss is a failure. In a tear-down step a miss sets error, but the remaining steps still run.
- R6: On a bring-up failure, the failing enable returns low. The enables raised earlier in the same sequence then fall in reverse order, and the sequence ends with error high.
- R7: A power-on request is refused unless the last init finished without error and no exit has been accepted since. A refused request leaves every enable unchanged and gives done and error high on the next cycle.
- R8: Requests that arrive while busy is high are ignored. When several requests arrive in the same idle cycle, the priority is init, then exit, then power-on, then power-off.
- R9: busy is high from the cycle after a request is accepted until the sequence ends. done is high for exactly one cycle per accepted request. error holds its value until the next accepted request.
- R10: While rst_n is low, all enables, busy, done and error are low.
- R11: At most one enable changes in any cycle, and the enables change only while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMO_W | Cycles allowed for an acknowledge after its enable changes |
| ext_clk_present | input | 1 | External reference clock fitted |
| vbus_present | input | 1 | VBUS supply switch fitted |
| req_init | input | 1 | Bring up link group (one-cycle pulse) |
| req_exit | input | 1 | Tear down link group (one-cycle pulse) |
| req_pon | input | 1 | Bring up PHY group (one-cycle pulse) |
| req_poff | input | 1 | Tear down PHY group (one-cycle pulse) |
| res_ack | input | 8 | Per-resource acknowledge, following its enable |
| res_en | output | 8 | Per-resource enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Last accepted request failed or was refused |

## Verification
The hardest situations to reach from the ports are a rollback that starts from the last bring-up step and a tear-down step whose acknowledge never falls. Neither happens while the resources behave. The bench therefore uses responders that can be told, request by request, to keep an acknowledge low or to keep it stuck high. It applies these faults on top of random response delays and random presence settings. A request injected in mid-sequence and a pair of requests issued in the same cycle cover the rules for ignoring and arbitrating requests.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int unsigned GRP_STEPS = 4;
  localparam int unsigned NUM_GRPS  = 2;
  localparam int unsigned NUM_RES   = GRP_STEPS * NUM_GRPS;
  localparam int unsigned POS_W     = $clog2(GRP_STEPS);
  localparam int unsigned RES_W     = $clog2(NUM_RES);

  // resource index = {group, step position}; order of bring-up is ascending
  localparam logic [RES_W-1:0] RES_LINK_CLK = RES_W'(0);
  localparam logic [RES_W-1:0] RES_AUX_CLK  = RES_W'(1);
  localparam logic [RES_W-1:0] RES_LINK_RST = RES_W'(2);
  localparam logic [RES_W-1:0] RES_AUX_RST  = RES_W'(3);
  localparam logic [RES_W-1:0] RES_EXT_CLK  = RES_W'(4);
  localparam logic [RES_W-1:0] RES_PHY_CLK  = RES_W'(5);
  localparam logic [RES_W-1:0] RES_PHY_RST  = RES_W'(6);
  localparam logic [RES_W-1:0] RES_VBUS     = RES_W'(7);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_INIT,
    OP_EXIT,
    OP_PON,
    OP_POFF
  } seq_op_e;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } seq_state_e;

  // fixed priority among simultaneous requests
  function automatic seq_op_e pick_op(logic r_init, logic r_exit,
                                      logic r_pon, logic r_poff);
    if (r_init)      return OP_INIT;
    else if (r_exit) return OP_EXIT;
    else if (r_pon)  return OP_PON;
    else if (r_poff) return OP_POFF;
    else             return OP_NONE;
  endfunction

  function automatic logic op_is_phy(seq_op_e op);
    return (op == OP_PON) || (op == OP_POFF);
  endfunction

  function automatic logic op_is_up(seq_op_e op);
    return (op == OP_INIT) || (op == OP_PON);
  endfunction

  function automatic logic [RES_W-1:0] res_of(logic grp, logic [POS_W-1:0] pos);
    return {grp, pos};
  endfunction

  function automatic logic res_absent(logic [RES_W-1:0] r, logic ext_p, logic vbus_p);
    return ((r == RES_EXT_CLK) && !ext_p) || ((r == RES_VBUS) && !vbus_p);
  endfunction

  function automatic logic [POS_W-1:0] first_pos(logic up);
    return up ? '0 : POS_W'(GRP_STEPS - 1);
  endfunction

  function automatic logic pos_is_last(logic up, logic [POS_W-1:0] pos);
    return up ? (pos == POS_W'(GRP_STEPS - 1)) : (pos == '0);
  endfunction

  function automatic logic [POS_W-1:0] pos_step(logic up, logic [POS_W-1:0] pos);
    return up ? pos + 1'b1 : pos - 1'b1;
  endfunction

endpackage

// File: rtl/phy_seq_req_arb.sv
module phy_seq_req_arb
  import phy_seq_pkg::*;
(
  input  logic    idle,
  input  logic    req_init,
  input  logic    req_exit,
  input  logic    req_pon,
  input  logic    req_poff,
  output seq_op_e op,
  output logic    accept
);

  always_comb begin
    op     = idle ? pick_op(req_init, req_exit, req_pon, req_poff) : OP_NONE;
    accept = (op != OP_NONE);
  end

endmodule

// File: rtl/phy_seq_step_timer.sv
module phy_seq_step_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);

endmodule

// File: rtl/phy_seq_en_bank.sv
module phy_seq_en_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             val,
  output logic [N-1:0]     en
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sel;
    assign sel = wr && (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   en[i] <= 1'b0;
      else if (sel) en[i] <= val;
    end
  end

endmodule

// File: rtl/phy_rsrc_seq.sv
module phy_rsrc_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TMO_W-1:0]   cfg_timeout,
  input  logic               ext_clk_present,
  input  logic               vbus_present,
  input  logic               req_init,
  input  logic               req_exit,
  input  logic               req_pon,
  input  logic               req_poff,
  input  logic [NUM_RES-1:0] res_ack,
  output logic [NUM_RES-1:0] res_en,
  output logic               busy,
  output logic               done,
  output logic               error
);

  seq_state_e       state_q;
  logic             grp_q;
  logic             up_q;
  logic [POS_W-1:0] pos_q;
  logic             fail_q;
  logic             link_ready_q;
  logic             done_q;
  logic             error_q;

  // named events
  seq_op_e          op;
  logic             accept;
  logic             pon_reject;
  logic             seq_start;
  logic             run;
  logic [RES_W-1:0] cur_res;
  logic             cur_skip;
  logic             step_ok;
  logic             tmo_hit;
  logic             step_fail;
  logic             up_fail;
  logic             step_end;
  logic             seq_last;
  logic             en_wr;
  logic             en_val;

  assign run = (state_q == ST_RUN);

  phy_seq_req_arb i_arb (
    .idle     (!run),
    .req_init (req_init),
    .req_exit (req_exit),
    .req_pon  (req_pon),
    .req_poff (req_poff),
    .op       (op),
    .accept   (accept)
  );

  assign pon_reject = accept && (op == OP_PON) && !link_ready_q;
  assign seq_start  = accept && !pon_reject;

  assign cur_res  = res_of(grp_q, pos_q);
  assign cur_skip = res_absent(cur_res, ext_clk_present, vbus_present);
  assign step_ok  = cur_skip ||
                    ((res_en[cur_res] == up_q) && (res_ack[cur_res] == up_q));

  phy_seq_step_timer #(.CNT_W(TMO_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!run || step_end),
    .limit   (cfg_timeout),
    .expired (tmo_hit)
  );

  assign step_fail = run && !step_ok && tmo_hit;
  assign up_fail   = step_fail && up_q;
  assign step_end  = run && (step_ok || tmo_hit);
  assign seq_last  = step_end &&
                     (up_fail ? (pos_q == '0) : pos_is_last(up_q, pos_q));

  // drive the current enable every running cycle; a failed bring-up drops it
  assign en_wr  = run && !cur_skip;
  assign en_val = up_q && !up_fail;

  phy_seq_en_bank #(.N(NUM_RES), .IDX_W(RES_W)) i_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (en_wr),
    .idx   (cur_res),
    .val   (en_val),
    .en    (res_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      grp_q        <= 1'b0;
      up_q         <= 1'b0;
      pos_q        <= '0;
      fail_q       <= 1'b0;
      link_ready_q <= 1'b0;
      done_q       <= 1'b0;
      error_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pon_reject) begin
        done_q  <= 1'b1;
        error_q <= 1'b1;
      end else if (seq_start) begin
        state_q <= ST_RUN;
        grp_q   <= op_is_phy(op);
        up_q    <= op_is_up(op);
        pos_q   <= first_pos(op_is_up(op));
        fail_q  <= 1'b0;
        error_q <= 1'b0;
        if (!op_is_phy(op)) link_ready_q <= 1'b0;
      end else if (step_end) begin
        if (seq_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          error_q <= fail_q || step_fail;
          if (up_q && !step_fail && !grp_q) link_ready_q <= 1'b1;
        end else begin
          if (step_fail) fail_q <= 1'b1;
          if (up_fail) begin
            up_q  <= 1'b0;
            pos_q <= pos_q - 1'b1;
          end else begin
            pos_q <= pos_step(up_q, pos_q);
          end
        end
      end
    end
  end

  assign busy  = run;
  assign done  = done_q;
  assign error = error_q;

endmodule

// File: rtl/phy_rsrc_seq_chk.sv
module phy_rsrc_seq_chk
  import phy_seq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_RES-1:0] res_en,
  input logic               busy,
  input logic               done,
  input logic               error,
  input logic               ext_clk_present,
  input logic               vbus_present,
  input logic               pon_reject
);

  assert_init_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_en[RES_AUX_RST]) |->
      (res_en[RES_LINK_RST] && res_en[RES_AUX_CLK] && res_en[RES_LINK_CLK]));

  assert_exit_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_en[RES_LINK_CLK]) |->
      !(res_en[RES_AUX_CLK] || res_en[RES_LINK_RST] || res_en[RES_AUX_RST]));

  assert_pon_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_en[RES_PHY_RST]) |-> res_en[RES_PHY_CLK]);

  assert_poff_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_en[RES_EXT_CLK]) |->
      !(res_en[RES_PHY_CLK] || res_en[RES_PHY_RST] || res_en[RES_VBUS]));

  assert_ext_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_en[RES_PHY_CLK]) |-> (res_en[RES_EXT_CLK] || !ext_clk_present));

  assert_vbus_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_en[RES_VBUS]) |-> vbus_present);

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pon_reject |=> (done && error && $stable(res_en)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(res_en ^ $past(res_en)) <= 1);

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_en != $past(res_en)) |-> $past(busy));

endmodule

bind phy_rsrc_seq phy_rsrc_seq_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .res_en          (res_en),
  .busy            (busy),
  .done            (done),
  .error           (error),
  .ext_clk_present (ext_clk_present),
  .vbus_present    (vbus_present),
  .pon_reject      (pon_reject)
);

// File: tb/test_phy_rsrc_seq.sv
module test_phy_rsrc_seq;
  import phy_seq_pkg::*;

  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_timeout = 16'(TMO);
  logic ext_p = 1'b1, vbus_p = 1'b1;
  logic r_init = 1'b0, r_exit = 1'b0, r_pon = 1'b0, r_poff = 1'b0;
  logic [NUM_RES-1:0] res_ack = '0;
  logic [NUM_RES-1:0] res_en;
  logic busy, done, error;

  always #2.5ns clk = ~clk;

  phy_rsrc_seq #(.TMO_W(16)) i_phy_rsrc_seq (
    .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
    .ext_clk_present(ext_p), .vbus_present(vbus_p),
    .req_init(r_init), .req_exit(r_exit), .req_pon(r_pon), .req_poff(r_poff),
    .res_ack(res_ack), .res_en(res_en), .busy(busy), .done(done), .error(error)
  );

  // acknowledge responders: follow enable after dly cycles, with fault knobs
  logic [7:0] dead_up = '0;
  logic [7:0] stuck_hi = '0;
  int dly [8];
  int rcnt [8] = '{default: 0};

  always @(posedge clk) begin
    for (int r = 0; r < 8; r++) begin
      if (res_en[r] != res_ack[r]) begin
        if (rcnt[r] >= dly[r] && !(res_en[r] && dead_up[r]) && !(!res_en[r] && stuck_hi[r])) begin
          res_ack[r] <= res_en[r];
          rcnt[r] <= 0;
        end else begin
          rcnt[r] <= rcnt[r] + 1;
        end
      end else begin
        rcnt[r] <= 0;
      end
    end
  end

  // monitor: enable edges and done pulses
  int n_chk = 0, n_err = 0, done_cnt = 0, log_n = 0;
  logic [3:0] ev_log [64];
  logic [7:0] prev_en = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      for (int r = 0; r < 8; r++) begin
        if (res_en[r] != prev_en[r]) begin
          if (log_n < 64) ev_log[log_n] = {res_en[r], 3'(r)};
          log_n++;
        end
      end
      prev_en = res_en;
    end
  end

  // reference model
  logic [7:0] m_en = '0;
  bit m_link = 1'b0;
  logic [3:0] exp_ev [64];
  int exp_n = 0;
  bit exp_err, m_rej, m_fail, m_stuck;

  function automatic bit absent(int r);
    return (r == 4 && !ext_p) || (r == 7 && !vbus_p);
  endfunction

  task automatic push(int r, bit v);
    exp_ev[exp_n] = {v, 3'(r)};
    exp_n++;
  endtask

  task automatic teardown_from(int g, int p0);
    for (int p = p0; p >= 0; p--) begin
      int r;
      r = g * 4 + p;
      if (!absent(r) && m_en[r]) begin
        push(r, 1'b0);
        m_en[r] = 1'b0;
        if (stuck_hi[r]) begin exp_err = 1'b1; m_stuck = 1'b1; end
      end
    end
  endtask

  // op: 1 init, 2 exit, 3 power-on, 4 power-off
  task automatic model(int op);
    int g, failp;
    bit up;
    exp_n = 0; exp_err = 0; m_rej = 0; m_fail = 0; m_stuck = 0;
    g = (op == 3 || op == 4) ? 1 : 0;
    up = (op == 1 || op == 3);
    if (op == 3 && !m_link) begin
      m_rej = 1; exp_err = 1;
    end else begin
      if (op == 1 || op == 2) m_link = 1'b0;
      if (up) begin
        failp = -1;
        for (int p = 0; p < 4; p++) begin
          int r;
          r = g * 4 + p;
          if (failp < 0 && !absent(r) && !m_en[r]) begin
            if (dead_up[r]) begin push(r, 1'b1); push(r, 1'b0); failp = p; end
            else begin push(r, 1'b1); m_en[r] = 1'b1; end
          end
        end
        if (failp >= 0) begin
          exp_err = 1; m_fail = 1;
          teardown_from(g, failp - 1);
        end else if (op == 1) begin
          m_link = 1'b1;
        end
      end else begin
        teardown_from(g, 3);
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1ns;
  endtask

  task automatic set_req(int op, logic v);
    case (op)
      1: r_init = v;
      2: r_exit = v;
      3: r_pon  = v;
      4: r_poff = v;
      default: ;
    endcase
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic run_op(int op, int same_op, int late_op, int late_wait, string tag);
    int w, bad;
    string etag;
    model(op);
    etag = m_rej ? "R7" : (m_stuck ? "R5" : (m_fail ? "R6" : tag));
    done_cnt = 0;
    log_n = 0;
    set_req(op, 1'b1);
    if (same_op != 0) set_req(same_op, 1'b1);
    tick();
    r_init = 0; r_exit = 0; r_pon = 0; r_poff = 0;
    chk(busy == !m_rej, "R9", "busy after request", int'(busy), int'(!m_rej));
    if (late_op != 0) begin
      repeat (late_wait) tick();
      chk(busy == 1'b1, "R8", "busy at late request", int'(busy), 1);
      set_req(late_op, 1'b1);
      tick();
      set_req(late_op, 1'b0);
    end
    w = 0;
    while (done_cnt == 0 && w < 4000) begin tick(); w++; end
    repeat (3) tick();
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(error == exp_err, etag, "error flag", int'(error), int'(exp_err));
    chk(log_n == exp_n, etag, "enable edge count", log_n, exp_n);
    if (log_n == exp_n) begin
      bad = -1;
      for (int k = 0; k < exp_n; k++)
        if (bad < 0 && ev_log[k] !== exp_ev[k]) bad = k;
      chk(bad < 0, etag, "enable edge order",
          (bad < 0) ? 0 : int'(ev_log[bad]), (bad < 0) ? 0 : int'(exp_ev[bad]));
    end
    chk(res_en == m_en, etag, "enables", int'(res_en), int'(m_en));
    if (op == 3) begin
      chk(!(res_en[4] && !ext_p), "R4", "absent ext clock enable", int'(res_en[4]), 0);
      chk(!(res_en[7] && !vbus_p), "R4", "absent vbus enable", int'(res_en[7]), 0);
    end
    dead_up = '0;
    stuck_hi = '0;
    repeat (12) tick();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog: got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 8; r++) dly[r] = 1;
    repeat (4) tick();
    // R10: reset state
    chk(res_en == '0 && !busy && !done && !error, "R10", "outputs in reset",
        int'({res_en, busy, done, error}), 0);
    rst_n = 1'b1;
    tick();
    chk(res_en == '0, "R10", "enables after reset", int'(res_en), 0);
    chk(!busy && !done && !error, "R10", "flags after reset", int'({busy, done, error}), 0);

    run_op(3, 0, 0, 0, "R7");          // power-on before init
    run_op(1, 0, 0, 0, "R1");
    run_op(3, 0, 0, 0, "R3");
    run_op(4, 0, 0, 0, "R3");
    run_op(2, 0, 0, 0, "R2");
    run_op(3, 0, 0, 0, "R7");          // refused again after exit

    // R4: optional resources absent
    ext_p = 1'b0; vbus_p = 1'b0;
    run_op(1, 0, 0, 0, "R1");
    run_op(3, 0, 0, 0, "R4");
    run_op(4, 0, 0, 0, "R4");
    run_op(2, 0, 0, 0, "R2");
    ext_p = 1'b1; vbus_p = 1'b1;

    // R5: slow acknowledge inside the timeout
    dly[5] = TMO - 5;
    run_op(1, 0, 0, 0, "R1");
    run_op(3, 0, 0, 0, "R5");
    run_op(4, 0, 0, 0, "R3");
    run_op(2, 0, 0, 0, "R2");
    dly[5] = 1;

    // R6: init fails at its last step, then power-on is refused
    dead_up[3] = 1'b1;
    run_op(1, 0, 0, 0, "R6");
    run_op(3, 0, 0, 0, "R7");
    // R6: power-on fails at VBUS, rollback 6,5,4
    run_op(1, 0, 0, 0, "R1");
    dead_up[7] = 1'b1;
    run_op(3, 0, 0, 0, "R6");
    // R5: tear-down timeout continues and reports error
    run_op(3, 0, 0, 0, "R3");
    stuck_hi[6] = 1'b1;
    run_op(4, 0, 0, 0, "R5");
    run_op(2, 0, 0, 0, "R2");

    // R8: simultaneous init and power-on, init wins
    run_op(1, 3, 0, 0, "R8");
    run_op(2, 0, 0, 0, "R2");
    // R8: exit arriving mid-init is ignored
    for (int r = 0; r < 8; r++) dly[r] = 6;
    run_op(1, 0, 2, 3, "R8");
    chk(done_cnt == 1, "R8", "no sequence from ignored request", done_cnt, 1);
    chk(res_en == m_en, "R8", "enables after ignored request", int'(res_en), int'(m_en));
    run_op(2, 0, 0, 0, "R2");

    // random rounds
    for (int it = 0; it < 30; it++) begin
      ext_p = 1'($urandom % 2);
      vbus_p = 1'($urandom % 2);
      for (int r = 0; r < 8; r++) dly[r] = int'($urandom % 9);
      if ($urandom % 4 == 0) dead_up[$urandom % 4] = 1'b1;
      run_op(1, 0, 0, 0, "R1");
      if ($urandom % 4 == 0) dead_up[4 + $urandom % 4] = 1'b1;
      run_op(3, 0, 0, 0, "R3");
      if ($urandom % 6 == 0) stuck_hi[4 + $urandom % 4] = 1'b1;
      run_op(4, 0, 0, 0, "R3");
      run_op(2, 0, 0, 0, "R2");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule